// File: doc/BRIEF.md
# Dual-Port Word Memory with Same-Address Busy Arbitration

This block is a clocked memory with two symmetric ports, left and right. Each port has its own active-low enable, a read/write select, an active-low output enable, an address, write data, registered read data with a valid flag, and a busy flag. Both ports reach one shared array of `2**ADDR_W` words of `DATA_W` bits. The full-size build uses `ADDR_W = 14` and `DATA_W = 8`, which gives 16384 bytes. The default parameters build a smaller array so that elaboration stays light.

In master mode (`ms_sel` high) an on-chip arbiter watches both ports in every cycle. When both ports are enabled on the same address and at least one of them writes, the left port wins. The arbiter raises the right port's busy flag combinationally in that same cycle, and the right port's write is dropped. In slave mode (`ms_sel` low) the arbiter stays silent and each port's write is gated by a busy input supplied from outside. This lets several devices share one master's decision when they are cascaded side by side to make a wider word.

Each port decodes its controls into one of four access kinds: `ACC_IDLE` (deselected), `ACC_WRITE`, `ACC_READ` and `ACC_MUTED` (enabled read with the outputs disabled). The kind is decoded afresh every cycle and has no stored state. The only registers are the read-data and valid registers of each port, which load at the clock edge that samples the access. The kind moves from any kind to any other kind on the next cycle's inputs.

Top module: `dpram_busy_arb`

## Requirements
- R1: With enable low (0) and read/write low (0, write) and no busy, a port stores its write data at its address at the clock edge. The word can then be read from either port.
- R2: With enable low, read/write high (1, read) and output enable low, the port presents the addressed word on its data output with the valid flag high, one clock after the edge that sampled the request.
- R3: With enable high (1, deselected), the port stores nothing. After the next edge its valid flag is low and its data output is zero.
- R4: With enable low, read/write high and output enable high (1), the port's valid flag is low and its data output is zero after the next edge, and the array is unchanged.
- R5: Both ports may read the same address in the same cycle. Both receive the word, and neither busy flag rises.
- R6: In master mode, when both ports are enabled on the same address and at least one writes, the right busy output (1 = busy) is high in that same cycle. The left busy output is never high.
- R7: In master mode, a right-port write that is flagged busy is discarded, so the word afterwards holds the left port's write data, or its previous value if the left port only read.
- R8: Busy clears in the cycle the addresses differ or either port is deselected. Writes to different addresses in the same cycle are both stored.
- R9: In slave mode both busy outputs stay low. A high busy input on a port discards that port's write, and in master mode the busy inputs have no effect.
- R10: While reset is asserted (low), both valid flags are low and both data outputs are zero.
- R11: A read returns the word as it stood before any write that the other port makes to the same address in the same cycle.
- R12: In slave mode with neither busy input high, two writes to one address in the same cycle leave the right port's data in the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the output registers only |
| ms_sel | input | 1 | 1 = master (on-chip arbitration), 0 = slave (external busy) |
| l_ce_n | input | 1 | Left enable, active low |
| l_rw | input | 1 | Left read/write select, 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data, zero when not valid |
| l_dvalid | output | 1 | Left read data valid |
| l_busy_o | output | 1 | Left busy from the arbiter |
| l_busy_i | input | 1 | Left busy supplied from outside (slave mode) |
| r_ce_n | input | 1 | Right enable, active low |
| r_rw | input | 1 | Right read/write select, 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data, zero when not valid |
| r_dvalid | output | 1 | Right read data valid |
| r_busy_o | output | 1 | Right busy from the arbiter |
| r_busy_i | input | 1 | Right busy supplied from outside (slave mode) |

## Verification
The two functions that meet in one cycle are one port's write and the other port's access to the same word. The bench provokes this by setting both ports to one address in a single cycle, in the combinations write/write and read/write, first in master mode and then in slave mode. It judges the busy flag a moment after the inputs settle, before the clock edge. It then judges the stored word by a later read through the ports and the same-cycle read data after the edge, and expects the old word there.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_MUTED = 2'd3
    } acc_e;

    localparam int NUM_PORTS = 2;
    localparam int LEFT_IDX  = 0;
    localparam int RIGHT_IDX = 1;

endpackage

// File: rtl/dpram_port_decode.sv
module dpram_port_decode
    import dpram_pkg::*;
(
    input  logic ce_n,
    input  logic rw,
    input  logic oe_n,
    input  logic block,
    output acc_e acc,
    output logic enabled,
    output logic wr_req,
    output logic wr_go,
    output logic rd_go
);

    always_comb begin
        if (ce_n)       acc = ACC_IDLE;
        else if (!rw)   acc = ACC_WRITE;
        else if (!oe_n) acc = ACC_READ;
        else            acc = ACC_MUTED;
    end

    always_comb begin
        enabled = 1'b0;
        wr_req  = 1'b0;
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        unique case (acc)
            ACC_IDLE: ;
            ACC_WRITE: begin
                enabled = 1'b1;
                wr_req  = 1'b1;
                wr_go   = !block;
            end
            ACC_READ: begin
                enabled = 1'b1;
                rd_go   = 1'b1;
            end
            ACC_MUTED: begin
                enabled = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
    parameter int ADDR_W = 11
) (
    input  logic              ms_sel,
    input  logic              l_en,
    input  logic              r_en,
    input  logic              l_wr,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_i,
    input  logic              r_busy_i,
    output logic              l_busy_o,
    output logic              r_busy_o,
    output logic              l_block,
    output logic              r_block
);

    logic same_addr;
    logic clash;

    assign same_addr = (l_addr == r_addr);
    assign clash     = l_en && r_en && same_addr && (l_wr || r_wr);

    always_comb begin
        if (ms_sel) begin
            l_busy_o = 1'b0;
            r_busy_o = clash;
            l_block  = 1'b0;
            r_block  = clash;
        end else begin
            l_busy_o = 1'b0;
            r_busy_o = 1'b0;
            l_block  = l_busy_i;
            r_block  = r_busy_i;
        end
    end

endmodule

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS-1:0]               we,
    input  logic [NUM_PORTS-1:0]               re,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   rdata,
    output logic [NUM_PORTS-1:0]               rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Ports are applied in index order, so the right port lands last.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (we[p]) mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g]  <= '0;
                rvalid[g] <= 1'b0;
            end else begin
                rvalid[g] <= re[g];
                rdata[g]  <= re[g] ? mem[addr[g]] : '0;
            end
        end
    end

endmodule

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_sel,
    input  logic              l_ce_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_dvalid,
    output logic              l_busy_o,
    input  logic              l_busy_i,
    input  logic              r_ce_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_dvalid,
    output logic              r_busy_o,
    input  logic              r_busy_i
);

    logic [NUM_PORTS-1:0]             ce_n_v, rw_v, oe_n_v, block_v;
    logic [NUM_PORTS-1:0]             en_v, wr_req_v, wr_go_v, rd_go_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] din_v, dout_v;
    logic [NUM_PORTS-1:0]             vld_v;
    acc_e                             acc_v [NUM_PORTS];

    assign ce_n_v = {r_ce_n, l_ce_n};
    assign rw_v   = {r_rw,   l_rw};
    assign oe_n_v = {r_oe_n, l_oe_n};
    assign addr_v = {r_addr, l_addr};
    assign din_v  = {r_din,  l_din};

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        dpram_port_decode u_dec (
            .ce_n    (ce_n_v[g]),
            .rw      (rw_v[g]),
            .oe_n    (oe_n_v[g]),
            .block   (block_v[g]),
            .acc     (acc_v[g]),
            .enabled (en_v[g]),
            .wr_req  (wr_req_v[g]),
            .wr_go   (wr_go_v[g]),
            .rd_go   (rd_go_v[g])
        );
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .ms_sel   (ms_sel),
        .l_en     (en_v[LEFT_IDX]),
        .r_en     (en_v[RIGHT_IDX]),
        .l_wr     (wr_req_v[LEFT_IDX]),
        .r_wr     (wr_req_v[RIGHT_IDX]),
        .l_addr   (l_addr),
        .r_addr   (r_addr),
        .l_busy_i (l_busy_i),
        .r_busy_i (r_busy_i),
        .l_busy_o (l_busy_o),
        .r_busy_o (r_busy_o),
        .l_block  (block_v[LEFT_IDX]),
        .r_block  (block_v[RIGHT_IDX])
    );

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_go_v),
        .re     (rd_go_v),
        .addr   (addr_v),
        .wdata  (din_v),
        .rdata  (dout_v),
        .rvalid (vld_v)
    );

    assign l_dout   = dout_v[LEFT_IDX];
    assign r_dout   = dout_v[RIGHT_IDX];
    assign l_dvalid = vld_v[LEFT_IDX];
    assign r_dvalid = vld_v[RIGHT_IDX];

endmodule

// File: rtl/dpram_busy_arb_chk.sv
module dpram_busy_arb_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_sel,
    input logic              l_ce_n,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_dout,
    input logic              l_dvalid,
    input logic              l_busy_o,
    input logic              r_ce_n,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_dout,
    input logic              r_dvalid,
    input logic              r_busy_o
);

    AST_LEFT_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_o); // R6

    AST_BUSY_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_sel && !l_ce_n && !r_ce_n && (l_addr == r_addr) && (!l_rw || !r_rw)) |-> r_busy_o); // R6

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n || r_ce_n || (l_addr != r_addr)) |-> !r_busy_o); // R8

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_sel |-> (!l_busy_o && !r_busy_o)); // R9

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && l_rw && !l_oe_n) |=> l_dvalid); // R2

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        r_ce_n |=> (!r_dvalid && r_dout == '0)); // R3

    AST_MUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && l_rw && l_oe_n) |=> (!l_dvalid && l_dout == '0)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!l_dvalid && !r_dvalid)); // R10

endmodule

bind dpram_busy_arb dpram_busy_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_sel   (ms_sel),
    .l_ce_n   (l_ce_n),
    .l_rw     (l_rw),
    .l_oe_n   (l_oe_n),
    .l_addr   (l_addr),
    .l_dout   (l_dout),
    .l_dvalid (l_dvalid),
    .l_busy_o (l_busy_o),
    .r_ce_n   (r_ce_n),
    .r_rw     (r_rw),
    .r_oe_n   (r_oe_n),
    .r_addr   (r_addr),
    .r_dout   (r_dout),
    .r_dvalid (r_dvalid),
    .r_busy_o (r_busy_o)
);

// File: tb/tb_dpram_busy_arb.sv
module tb_dpram_busy_arb;

    localparam int AW = 11;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ms_sel;
    logic          l_ce_n, l_rw, l_oe_n, l_busy_i;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_din;
    logic [DW-1:0] l_dout;
    logic          l_dvalid, l_busy_o;
    logic          r_ce_n, r_rw, r_oe_n, r_busy_i;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_din;
    logic [DW-1:0] r_dout;
    logic          r_dvalid, r_busy_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dpram_busy_arb #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
        .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_din(l_din),
        .l_dout(l_dout), .l_dvalid(l_dvalid), .l_busy_o(l_busy_o), .l_busy_i(l_busy_i),
        .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_din(r_din),
        .r_dout(r_dout), .r_dvalid(r_dvalid), .r_busy_o(r_busy_o), .r_busy_i(r_busy_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_all();
        l_ce_n = 1'b1; l_rw = 1'b1; l_oe_n = 1'b1; l_addr = '0; l_din = '0; l_busy_i = 1'b0;
        r_ce_n = 1'b1; r_rw = 1'b1; r_oe_n = 1'b1; r_addr = '0; r_din = '0; r_busy_i = 1'b0;
    endtask

    task automatic set_l(input logic ce_n, input logic rw, input logic oe_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_ce_n = ce_n; l_rw = rw; l_oe_n = oe_n; l_addr = a; l_din = d;
    endtask

    task automatic set_r(input logic ce_n, input logic rw, input logic oe_n,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_ce_n = ce_n; r_rw = rw; r_oe_n = oe_n; r_addr = a; r_din = d;
    endtask

    task automatic write_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle_all(); set_l(1'b0, 1'b0, 1'b1, a, d); step(); idle_all();
    endtask

    task automatic read_r_expect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle_all(); set_r(1'b0, 1'b1, 1'b0, a, '0); step();
        check(req, {31'd0, r_dvalid}, 32'd1);
        check(req, {24'd0, r_dout}, {24'd0, d});
        idle_all();
    endtask

    task automatic read_l_expect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle_all(); set_l(1'b0, 1'b1, 1'b0, a, '0); step();
        check(req, {31'd0, l_dvalid}, 32'd1);
        check(req, {24'd0, l_dout}, {24'd0, d});
        idle_all();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ms_sel = 1'b1; idle_all();
        repeat (3) step();
        check("R10 l_dvalid", {31'd0, l_dvalid}, 32'd0);
        check("R10 r_dvalid", {31'd0, r_dvalid}, 32'd0);
        check("R10 l_dout", {24'd0, l_dout}, 32'd0);
        check("R10 r_dout", {24'd0, r_dout}, 32'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_write_read();
        write_l(11'd5, 8'hA5);
        idle_all(); set_r(1'b0, 1'b0, 1'b1, 11'd100, 8'h3C); step(); idle_all();
        read_r_expect("R1 R2 left write seen on right", 11'd5, 8'hA5);
        read_l_expect("R1 R2 right write seen on left", 11'd100, 8'h3C);
    endtask

    task automatic t_deselect();
        idle_all(); set_l(1'b1, 1'b0, 1'b0, 11'd5, 8'hFF); step();
        check("R3 deselected valid", {31'd0, l_dvalid}, 32'd0);
        check("R3 deselected dout", {24'd0, l_dout}, 32'd0);
        read_r_expect("R3 deselected write ignored", 11'd5, 8'hA5);
    endtask

    task automatic t_muted();
        idle_all(); set_l(1'b0, 1'b1, 1'b1, 11'd5, 8'h00); step();
        check("R4 muted valid", {31'd0, l_dvalid}, 32'd0);
        check("R4 muted dout", {24'd0, l_dout}, 32'd0);
        read_r_expect("R4 array unchanged", 11'd5, 8'hA5);
    endtask

    task automatic t_same_read();
        idle_all();
        set_l(1'b0, 1'b1, 1'b0, 11'd5, 8'h00);
        set_r(1'b0, 1'b1, 1'b0, 11'd5, 8'h00);
        #1;
        check("R5 no busy on shared read", {30'd0, l_busy_o, r_busy_o}, 32'd0);
        step();
        check("R5 left data", {23'd0, l_dvalid, l_dout}, {23'd0, 1'b1, 8'hA5});
        check("R5 right data", {23'd0, r_dvalid, r_dout}, {23'd0, 1'b1, 8'hA5});
        idle_all();
    endtask

    task automatic t_clash();
        idle_all();
        set_l(1'b0, 1'b0, 1'b1, 11'd7, 8'h11);
        set_r(1'b0, 1'b0, 1'b1, 11'd7, 8'h22);
        #1;
        check("R6 right busy on write clash", {31'd0, r_busy_o}, 32'd1);
        check("R6 left never busy", {31'd0, l_busy_o}, 32'd0);
        step(); idle_all();
        read_l_expect("R7 left write kept", 11'd7, 8'h11);
        idle_all();
        set_l(1'b0, 1'b1, 1'b0, 11'd7, 8'h00);
        set_r(1'b0, 1'b0, 1'b1, 11'd7, 8'h99);
        #1;
        check("R6 right busy on read/write clash", {31'd0, r_busy_o}, 32'd1);
        step();
        check("R7 left read during clash", {24'd0, l_dout}, 32'h11);
        idle_all();
        read_r_expect("R7 busy right write dropped", 11'd7, 8'h11);
    endtask

    task automatic t_read_before_write();
        idle_all();
        set_l(1'b0, 1'b0, 1'b1, 11'd7, 8'h44);
        set_r(1'b0, 1'b1, 1'b0, 11'd7, 8'h00);
        step();
        check("R11 right sees old word", {23'd0, r_dvalid, r_dout}, {23'd0, 1'b1, 8'h11});
        idle_all();
        read_r_expect("R11 left write landed", 11'd7, 8'h44);
    endtask

    task automatic t_release();
        idle_all();
        set_l(1'b0, 1'b0, 1'b1, 11'd8, 8'h55);
        set_r(1'b0, 1'b0, 1'b1, 11'd8, 8'h66);
        #1;
        check("R8 busy while matched", {31'd0, r_busy_o}, 32'd1);
        r_addr = 11'd9;
        #1;
        check("R8 busy drops on address change", {31'd0, r_busy_o}, 32'd0);
        step(); idle_all();
        read_r_expect("R8 left write stored", 11'd8, 8'h55);
        read_l_expect("R8 right write stored", 11'd9, 8'h66);
    endtask

    task automatic t_slave();
        ms_sel = 1'b0;
        idle_all();
        set_l(1'b0, 1'b0, 1'b1, 11'd10, 8'h01);
        set_r(1'b0, 1'b0, 1'b1, 11'd10, 8'h02);
        #1;
        check("R9 slave busy outputs low", {30'd0, l_busy_o, r_busy_o}, 32'd0);
        step(); idle_all();
        read_l_expect("R12 right data wins in slave", 11'd10, 8'h02);
        write_l(11'd11, 8'h70);
        idle_all(); set_r(1'b0, 1'b0, 1'b1, 11'd11, 8'h77); r_busy_i = 1'b1; step(); idle_all();
        read_l_expect("R9 right busy input drops write", 11'd11, 8'h70);
        idle_all(); set_l(1'b0, 1'b0, 1'b1, 11'd11, 8'h78); l_busy_i = 1'b1; step(); idle_all();
        read_r_expect("R9 left busy input drops write", 11'd11, 8'h70);
        ms_sel = 1'b1;
        idle_all(); set_r(1'b0, 1'b0, 1'b1, 11'd12, 8'h5A); r_busy_i = 1'b1; step(); idle_all();
        read_l_expect("R9 busy input ignored in master", 11'd12, 8'h5A);
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write_read();
        t_deselect();
        t_muted();
        t_same_read();
        t_clash();
        t_read_before_write();
        t_release();
        t_slave();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule